// File: doc/BRIEF.md
# Privileged Return and Trap Check Unit

This block executes four privileged control instructions for one hart that has machine (M), supervisor (S) and user (U) modes. The instructions are the machine-level return, the supervisor-level return, wait-for-interrupt and the address-translation fence. An upstream decoder presents each instruction as a one-cycle strobe. The strobe carries a two-bit operation class, the instruction address, the current privilege level, the status bits that the returns consume and the two trap-control bits. It also carries both exception-PC registers and a flag that says whether U mode exists.

Each instruction produces exactly one result. In the first case the block commits: a new PC, a new privilege level and new status bits, all valid in the same cycle under a single commit strobe. The second case is an illegal-instruction trap request with cause 2 and a zero trap value. The trap-entry sequence, TLB maintenance and interrupt delivery belong to neighbouring blocks.

The control is a three-state machine.
- ST_IDLE: no result is presented.
- ST_COMMIT: a legal instruction's updates are presented.
- ST_TRAP: a trap request is presented.

The machine samples the strobe on every clock edge. With no strobe, every state goes to ST_IDLE. A strobe for a legal instruction goes to ST_COMMIT, and a strobe for an illegal one goes to ST_TRAP, whatever the current state. Back-to-back instructions are therefore accepted on every cycle.

Top module: `priv_ret_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, commit, redirect, return-done and trap-request outputs are all low.
- R2: A machine return (operation 2'b00) issued at any level other than M (encoding 2'b11) raises a trap request with cause 2, a trap value of 0 and next_pc equal to the instruction address. Commit stays low, and the status and privilege outputs repeat the inputs unchanged.
- R3: A supervisor return (operation 2'b01) traps in U (2'b00), in the reserved level 2'b10, and in S (2'b01) while the return-trap control bit is 1. It is legal in M.
- R4: A legal machine return redirects to the machine exception PC. It sets the machine interrupt enable to the old machine previous-enable, sets the previous-enable to 1, and takes the old machine previous-privilege as the new level. A reserved previous-privilege of 2'b10 returns to U when U exists and to M when it does not.
- R5: After a legal machine return, the machine previous-privilege field reads U (2'b00) when U mode is implemented and M (2'b11) when it is not.
- R6: A legal supervisor return redirects to the supervisor exception PC. It sets the supervisor interrupt enable to the old supervisor previous-enable and sets that previous-enable to 1. It returns to S if the one-bit supervisor previous-privilege was 1 and to U if it was 0, then clears that bit.
- R7: The fence (operation 2'b11) traps in U, in level 2'b10, and in S while the virtual-memory trap control bit is 1. Otherwise it commits with next_pc equal to the address plus 4, no redirect, and status and privilege unchanged.
- R8: Wait-for-interrupt (operation 2'b10) commits at every level with next_pc equal to the address plus 4, no redirect, and status and privilege unchanged.
- R9: Every result appears on the clock edge that follows its strobe. Commit and trap request are never high together, and the redirect and return-done strobes are high exactly on committed returns.
- R10: A cycle without a strobe yields neither a commit nor a trap request on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction strobe |
| insn_op | input | 2 | Operation class: 00 machine return, 01 supervisor return, 10 wait, 11 fence |
| insn_pc | input | XLEN | Instruction address |
| cur_priv | input | 2 | Current privilege level (U=00, S=01, M=11) |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege (1 = S) |
| st_tsr | input | 1 | Trap control for supervisor return |
| st_tvm | input | 1 | Trap control for the fence |
| mepc | input | XLEN | Machine exception PC |
| sepc | input | XLEN | Supervisor exception PC |
| umode_present | input | 1 | U mode is implemented |
| commit | output | 1 | Updates below are valid and take effect |
| redirect | output | 1 | Branch-taken strobe for a return |
| xret_done | output | 1 | Return-from-trap pulse |
| next_pc | output | XLEN | Next PC, or faulting address on a trap |
| nx_priv | output | 2 | New privilege level |
| nx_mie | output | 1 | New machine interrupt enable |
| nx_mpie | output | 1 | New machine previous enable |
| nx_mpp | output | 2 | New machine previous privilege |
| nx_sie | output | 1 | New supervisor interrupt enable |
| nx_spie | output | 1 | New supervisor previous enable |
| nx_spp | output | 1 | New supervisor previous privilege |
| trap_req | output | 1 | Illegal-instruction trap request |
| trap_cause | output | CAUSE_W | Trap cause, 2 on a trap |
| trap_tval | output | XLEN | Trap value, 0 on a trap |

## Verification
Every result of this block is due exactly one clock edge after its strobe. This applies to commit or trap, the redirect and return-done pulses, the next PC and each status field. The bench drives each strobe just after a falling edge and computes the expected result from its own model of the requirements. It compares all outputs at the next falling edge, which lies half a period after the one register stage. Cycles without a strobe are checked only for quiet strobes, because the payload outputs are then undefined by contract.

// File: rtl/priv_ret_pkg.sv
package priv_ret_pkg;

    typedef enum logic [1:0] {
        PRV_U    = 2'b00,
        PRV_S    = 2'b01,
        PRV_RSVD = 2'b10,
        PRV_M    = 2'b11
    } prv_e;

    typedef enum logic [1:0] {
        OP_MRET   = 2'b00,
        OP_SRET   = 2'b01,
        OP_WFI    = 2'b10,
        OP_SFENCE = 2'b11
    } op_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       sie;
        logic       spie;
        logic       spp;
    } stat_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COMMIT = 2'b01,
        ST_TRAP   = 2'b10
    } fsm_e;

    localparam int unsigned ILLEGAL_INSN_CAUSE = 2;
    localparam int unsigned INSN_BYTES         = 4;

endpackage

// File: rtl/priv_ret_legal.sv
// Decides, per operation class, whether the current level and trap controls
// allow the instruction to complete.
module priv_ret_legal
    import priv_ret_pkg::*;
(
    input  logic [1:0] op,
    input  logic [1:0] priv,
    input  logic       tsr,
    input  logic       tvm,
    output logic       legal,
    output logic       is_return
);
    logic at_m;
    logic at_s;

    always_comb begin
        at_m      = (priv == PRV_M);
        at_s      = (priv == PRV_S);
        legal     = 1'b0;
        is_return = 1'b0;
        unique case (op)
            OP_MRET: begin
                legal     = at_m;
                is_return = 1'b1;
            end
            OP_SRET: begin
                legal     = at_m || (at_s && !tsr);
                is_return = 1'b1;
            end
            OP_WFI: begin
                legal     = 1'b1;
            end
            OP_SFENCE: begin
                legal     = at_m || (at_s && !tvm);
            end
            default: begin
                legal     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/priv_ret_update.sv
// Computes the status, privilege and PC that a legal instruction commits.
module priv_ret_update
    import priv_ret_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [1:0]      priv,
    input  stat_t           st,
    input  logic            umode_present,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    output stat_t           nst,
    output logic [1:0]      npriv,
    output logic [XLEN-1:0] npc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [1:0] lowest_level;

    always_comb begin
        lowest_level = umode_present ? PRV_U : PRV_M;
        nst          = st;
        npriv        = priv;
        npc          = pc + STEP;
        unique case (op)
            OP_MRET: begin
                nst.mie  = st.mpie;
                nst.mpie = 1'b1;
                nst.mpp  = lowest_level;
                npriv    = (st.mpp == PRV_RSVD) ? lowest_level : st.mpp;
                npc      = mepc;
            end
            OP_SRET: begin
                nst.sie  = st.spie;
                nst.spie = 1'b1;
                nst.spp  = 1'b0;
                npriv    = st.spp ? PRV_S : PRV_U;
                npc      = sepc;
            end
            default: begin
                nst   = st;
                npriv = priv;
                npc   = pc + STEP;
            end
        endcase
    end
endmodule

// File: rtl/priv_ret_unit.sv
module priv_ret_unit
    import priv_ret_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_valid,
    input  logic [1:0]         insn_op,
    input  logic [XLEN-1:0]    insn_pc,
    input  logic [1:0]         cur_priv,
    input  logic               st_mie,
    input  logic               st_mpie,
    input  logic [1:0]         st_mpp,
    input  logic               st_sie,
    input  logic               st_spie,
    input  logic               st_spp,
    input  logic               st_tsr,
    input  logic               st_tvm,
    input  logic [XLEN-1:0]    mepc,
    input  logic [XLEN-1:0]    sepc,
    input  logic               umode_present,
    output logic               commit,
    output logic               redirect,
    output logic               xret_done,
    output logic [XLEN-1:0]    next_pc,
    output logic [1:0]         nx_priv,
    output logic               nx_mie,
    output logic               nx_mpie,
    output logic [1:0]         nx_mpp,
    output logic               nx_sie,
    output logic               nx_spie,
    output logic               nx_spp,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_tval
);
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(ILLEGAL_INSN_CAUSE);

    stat_t           st_in;
    stat_t           st_upd;
    logic [1:0]      priv_upd;
    logic [XLEN-1:0] pc_upd;
    logic            is_legal;
    logic            is_ret;

    fsm_e            state_q;
    fsm_e            state_d;
    stat_t           st_q;
    logic [1:0]      priv_q;
    logic [XLEN-1:0] pc_q;
    logic            ret_q;

    assign st_in = '{mie: st_mie, mpie: st_mpie, mpp: st_mpp,
                     sie: st_sie, spie: st_spie, spp: st_spp};

    priv_ret_legal u_legal (
        .op        (insn_op),
        .priv      (cur_priv),
        .tsr       (st_tsr),
        .tvm       (st_tvm),
        .legal     (is_legal),
        .is_return (is_ret)
    );

    priv_ret_update #(.XLEN(XLEN)) u_update (
        .op            (insn_op),
        .priv          (cur_priv),
        .st            (st_in),
        .umode_present (umode_present),
        .pc            (insn_pc),
        .mepc          (mepc),
        .sepc          (sepc),
        .nst           (st_upd),
        .npriv         (priv_upd),
        .npc           (pc_upd)
    );

    // Next-state selection: every state follows the incoming strobe.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_COMMIT, ST_TRAP: begin
                if (!insn_valid)    state_d = ST_IDLE;
                else if (is_legal)  state_d = ST_COMMIT;
                else                state_d = ST_TRAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result payload: the updated values on a legal instruction, the
    // unchanged inputs and the faulting address on an illegal one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            priv_q <= PRV_M;
            pc_q   <= '0;
            ret_q  <= 1'b0;
        end else if (insn_valid) begin
            if (is_legal) begin
                st_q   <= st_upd;
                priv_q <= priv_upd;
                pc_q   <= pc_upd;
                ret_q  <= is_ret;
            end else begin
                st_q   <= st_in;
                priv_q <= cur_priv;
                pc_q   <= insn_pc;
                ret_q  <= 1'b0;
            end
        end
    end

    // Output decode from the state register.
    always_comb begin
        commit     = 1'b0;
        redirect   = 1'b0;
        xret_done  = 1'b0;
        trap_req   = 1'b0;
        trap_cause = '0;
        trap_tval  = '0;
        unique case (state_q)
            ST_IDLE: begin
                commit = 1'b0;
            end
            ST_COMMIT: begin
                commit    = 1'b1;
                redirect  = ret_q;
                xret_done = ret_q;
            end
            ST_TRAP: begin
                trap_req   = 1'b1;
                trap_cause = CAUSE_ILLEGAL;
                trap_tval  = '0;
            end
            default: begin
                commit = 1'b0;
            end
        endcase
        next_pc = pc_q;
        nx_priv = priv_q;
        nx_mie  = st_q.mie;
        nx_mpie = st_q.mpie;
        nx_mpp  = st_q.mpp;
        nx_sie  = st_q.sie;
        nx_spie = st_q.spie;
        nx_spp  = st_q.spp;
    end

    // R2: machine return below M must trap with cause 2
    p_mret_below_m_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_MRET && cur_priv != PRV_M)
        |=> (trap_req && !commit && trap_cause == CAUSE_ILLEGAL));

    // R3: supervisor return in S with return-trap control set must trap
    p_sret_tsr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_SRET && cur_priv == PRV_S && st_tsr)
        |=> trap_req);

    // R4: legal machine return redirects to the machine exception PC
    p_mret_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_MRET && cur_priv == PRV_M)
        |=> (redirect && next_pc == $past(mepc) && nx_mie == $past(st_mpie) && nx_mpie));

    // R5: previous-privilege after machine return depends on U presence
    p_mret_mpp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_MRET && cur_priv == PRV_M)
        |=> (nx_mpp == ($past(umode_present) ? PRV_U : PRV_M)));

    // R6: legal supervisor return clears SPP and sets SPIE
    p_sret_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_SRET && cur_priv == PRV_M)
        |=> (commit && !nx_spp && nx_spie && next_pc == $past(sepc)));

    // R7: fence in U must trap
    p_fence_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_SFENCE && cur_priv == PRV_U)
        |=> trap_req);

    // R8: wait always commits without redirect
    p_wfi_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == OP_WFI)
        |=> (commit && !redirect));

    // R9: every strobe yields exactly one kind of result next cycle
    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> (commit != trap_req));

    // R10: a quiet cycle yields a quiet result
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> (!commit && !trap_req && !xret_done));

endmodule

// File: tb/priv_ret_unit_tb.sv
module priv_ret_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int CW         = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            insn_valid;
    logic [1:0]      insn_op;
    logic [XLEN-1:0] insn_pc;
    logic [1:0]      cur_priv;
    logic            st_mie, st_mpie, st_sie, st_spie, st_spp, st_tsr, st_tvm;
    logic [1:0]      st_mpp;
    logic [XLEN-1:0] mepc, sepc;
    logic            umode_present;
    logic            commit, redirect, xret_done, trap_req;
    logic [XLEN-1:0] next_pc, trap_tval;
    logic [1:0]      nx_priv, nx_mpp;
    logic            nx_mie, nx_mpie, nx_sie, nx_spie, nx_spp;
    logic [CW-1:0]   trap_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_ret_unit #(.XLEN(XLEN), .CAUSE_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_op(insn_op),
        .insn_pc(insn_pc), .cur_priv(cur_priv), .st_mie(st_mie), .st_mpie(st_mpie),
        .st_mpp(st_mpp), .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp),
        .st_tsr(st_tsr), .st_tvm(st_tvm), .mepc(mepc), .sepc(sepc),
        .umode_present(umode_present), .commit(commit), .redirect(redirect),
        .xret_done(xret_done), .next_pc(next_pc), .nx_priv(nx_priv),
        .nx_mie(nx_mie), .nx_mpie(nx_mpie), .nx_mpp(nx_mpp), .nx_sie(nx_sie),
        .nx_spie(nx_spie), .nx_spp(nx_spp), .trap_req(trap_req),
        .trap_cause(trap_cause), .trap_tval(trap_tval)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One instruction (or idle cycle): drive after a falling edge, compare
    // the model's result at the next falling edge.
    task automatic step(input bit v, input logic [1:0] op, input logic [1:0] prv,
                        input logic [6:0] st, input bit tsr, input bit tvm,
                        input bit um, input logic [XLEN-1:0] pc);
        bit legal, is_ret;
        logic [1:0] e_priv, e_mpp, lowest;
        logic e_mie, e_mpie, e_sie, e_spie, e_spp;
        logic [XLEN-1:0] e_pc;
        string rq;
        insn_valid = v; insn_op = op; cur_priv = prv; insn_pc = pc;
        {st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp} = st;
        st_tsr = tsr; st_tvm = tvm; umode_present = um;
        mepc = pc ^ 32'h5A5A_0F00; sepc = pc ^ 32'h00C3_3C00;
        // model
        {e_mie, e_mpie, e_mpp, e_sie, e_spie, e_spp} = st;
        e_priv = prv; e_pc = pc + 4; is_ret = 0;
        lowest = um ? 2'b00 : 2'b11;
        case (op)
            2'd0: begin legal = (prv == 2'b11); rq = legal ? "R4" : "R2"; end
            2'd1: begin legal = (prv == 2'b11) || (prv == 2'b01 && !tsr); rq = legal ? "R6" : "R3"; end
            2'd2: begin legal = 1; rq = "R8"; end
            default: begin legal = (prv == 2'b11) || (prv == 2'b01 && !tvm); rq = "R7"; end
        endcase
        if (legal && op == 2'd0) begin
            is_ret = 1; e_pc = mepc; e_mie = st[5]; e_mpie = 1;
            e_priv = (st[4:3] == 2'b10) ? lowest : st[4:3]; e_mpp = lowest;
        end else if (legal && op == 2'd1) begin
            is_ret = 1; e_pc = sepc; e_sie = st[1]; e_spie = 1;
            e_priv = st[0] ? 2'b01 : 2'b00; e_spp = 0;
        end else if (!legal) begin
            e_pc = pc;
        end
        @(negedge clk);
        if (!v) begin
            chk("R10", "commit", commit, 0);
            chk("R10", "trap_req", trap_req, 0);
            chk("R10", "xret_done", xret_done, 0);
            return;
        end
        chk("R9", "commit", commit, legal);
        chk(rq, "trap_req", trap_req, !legal);
        chk("R9", "redirect", redirect, legal && is_ret);
        chk("R9", "xret_done", xret_done, legal && is_ret);
        chk(rq, "next_pc", next_pc, e_pc);
        chk(rq, "nx_priv", nx_priv, e_priv);
        chk(rq, "status", {nx_mie, nx_mpie, nx_sie, nx_spie, nx_spp},
            {e_mie, e_mpie, e_sie, e_spie, e_spp});
        chk((legal && op == 2'd0) ? "R5" : rq, "nx_mpp", nx_mpp, e_mpp);
        if (!legal) begin
            chk(rq, "trap_cause", trap_cause, 2);
            chk(rq, "trap_tval", trap_tval, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; insn_valid = 0; insn_op = 0; insn_pc = 0; cur_priv = 2'b11;
        {st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp} = '0;
        st_tsr = 0; st_tvm = 0; mepc = 0; sepc = 0; umode_present = 1;
        repeat (3) @(negedge clk);
        // R1: strobes quiet under reset
        chk("R1", "commit", commit, 0);
        chk("R1", "trap_req", trap_req, 0);
        chk("R1", "redirect", redirect, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "xret_done after reset", xret_done, 0);
        chk("R1", "trap_req after reset", trap_req, 0);

        // R2: machine return from S and U
        step(1, 2'd0, 2'b01, 7'b0101101, 0, 0, 1, 32'h1000);
        step(1, 2'd0, 2'b00, 7'b0101101, 0, 0, 1, 32'h1004);
        // R4/R5: legal machine return with and without U
        step(1, 2'd0, 2'b11, 7'b0101010, 0, 0, 1, 32'h2000);
        step(1, 2'd0, 2'b11, 7'b0100110, 0, 0, 0, 32'h2004);
        step(1, 2'd0, 2'b11, 7'b1010001, 0, 0, 1, 32'h2008); // reserved MPP, R4
        step(1, 2'd0, 2'b11, 7'b1010001, 0, 0, 0, 32'h200C); // reserved MPP, no U
        // R3: supervisor return traps
        step(1, 2'd1, 2'b00, 7'b0000011, 0, 0, 1, 32'h3000);
        step(1, 2'd1, 2'b01, 7'b0000011, 1, 0, 1, 32'h3004);
        step(1, 2'd1, 2'b10, 7'b0000011, 0, 0, 1, 32'h3008);
        // R6: legal supervisor returns
        step(1, 2'd1, 2'b01, 7'b0000011, 0, 0, 1, 32'h3100);
        step(1, 2'd1, 2'b11, 7'b0000100, 1, 0, 1, 32'h3104);
        // R7: fence
        step(1, 2'd3, 2'b00, 7'b1111111, 0, 0, 1, 32'h4000);
        step(1, 2'd3, 2'b01, 7'b1111111, 0, 1, 1, 32'h4004);
        step(1, 2'd3, 2'b01, 7'b1111111, 0, 0, 1, 32'h4008);
        step(1, 2'd3, 2'b11, 7'b1111111, 0, 1, 1, 32'h400C);
        // R8: wait at each level
        step(1, 2'd2, 2'b00, 7'b0011000, 1, 1, 1, 32'h5000);
        step(1, 2'd2, 2'b01, 7'b0011000, 1, 1, 1, 32'h5004);
        step(1, 2'd2, 2'b11, 7'b0011000, 1, 1, 0, 32'hFFFF_FFFC);
        // R10: idle cycles
        step(0, 2'd0, 2'b11, 7'b0, 0, 0, 1, 32'h6000);
        step(0, 2'd1, 2'b00, 7'b0, 0, 0, 1, 32'h6004);
        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, 2'($urandom), 2'($urandom), 7'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), {$urandom} & 32'hFFFF_FFFC);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule